// File: doc/BRIEF.md
# System Clock Select and Standby Control

This block produces the processor's machine-cycle strobe from one of two oscillators. The fast main oscillator and the slow subsystem oscillator each reach the block as a one-cycle enable pulse per period, synchronous to the block clock. The strobe `phi_tick` pulses once per machine cycle. With the main source it fires every 4, 8 or 64 main ticks, chosen by a two-bit speed field. With the subsystem source it fires every 4 subsystem ticks. At 4.19 MHz these ratios give machine cycles of about 0.95 µs, 1.91 µs and 15.3 µs, and 122 µs on a 32.768 kHz subsystem crystal. A new speed field or source is held pending and only takes effect when a machine cycle ends, so no machine cycle is ever cut short.

The block also runs the two standby modes. A halt command freezes the strobe while both oscillators keep running. A stop command also raises `osc_disable`, which turns off the main oscillator. Either mode ends on an interrupt standby release. Leaving stop clears the speed field to the slowest main rate. The strobe then stays frozen until the interval timer signals that the oscillator has settled. A reset ends either mode at once. A free-running divider on the main ticks supplies peripheral tick pulses at fX/8 up to fX/4096; it halts while the oscillator is off.

Top module: `sysclk_standby_ctrl`

## Requirements
- R1: After reset `phi_tick`, `osc_disable`, `sub_active` and every `periph_tick` bit are 0. `speed_q` is 2'b00. The main source is selected.
- R2: With the main source, `phi_tick` pulses once every 4 main ticks for speed field 2'b11, every 8 for 2'b10, and every 64 for 2'b00 or 2'b01. Each pulse lasts exactly one cycle.
- R3: Writing `scc_sub`=1 selects the subsystem source. `phi_tick` then pulses once every 4 `fxt_tick` pulses, and `sub_active` reads 1.
- R4: A speed or source write is applied only at a machine-cycle boundary. The interval in progress completes at the old ratio. `speed_q` and `sub_active` change only in the same cycle as a `phi_tick` pulse, or when stop is left.
- R5: A halt command in run mode stops `phi_tick` from the cycle after it is registered. `osc_disable` stays 0 during halt. An `int_release` returns the block to run mode.
- R6: A stop command in run mode raises `osc_disable` on the next cycle. While `osc_disable` is 1, main ticks are ignored: the peripheral divider holds and no `periph_tick` fires.
- R7: An `int_release` during stop drops `osc_disable` and forces `speed_q`, and the pending speed, to 2'b00 on the next cycle. `phi_tick` then stays 0 until `bt_release`.
- R8: Stop wins over halt when both are commanded in the same cycle. Halt and stop commands are ignored while in a standby mode. `int_release` in run mode and `bt_release` outside the post-stop wait have no effect.
- R9: `periph_tick[k]` pulses once every 2^(k+3) effective main ticks. Bit 0 is fX/8 and bit 9 is fX/4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fx_tick | input | 1 | Main oscillator tick enable |
| fxt_tick | input | 1 | Subsystem oscillator tick enable |
| pcc_wr | input | 1 | Speed field write strobe |
| pcc_speed | input | 2 | Speed field value (11 fast, 10 mid, 00/01 slow) |
| scc_wr | input | 1 | Source select write strobe |
| scc_sub | input | 1 | Source select value (1 = subsystem) |
| halt_cmd | input | 1 | Enter halt strobe |
| stop_cmd | input | 1 | Enter stop strobe |
| int_release | input | 1 | Interrupt standby release |
| bt_release | input | 1 | Interval timer wait release |
| phi_tick | output | 1 | Machine-cycle strobe |
| osc_disable | output | 1 | Main oscillator disable |
| speed_q | output | 2 | Speed field currently applied |
| sub_active | output | 1 | Subsystem source currently applied |
| periph_tick | output | 10 | Peripheral divider taps fX/8 to fX/4096 |

## Verification
All outputs are registered. A strobe or source tick seen at one edge shows up at the ports one cycle later: `phi_tick` and `periph_tick` follow the source tick that completes the count, and `osc_disable` and the cleared `speed_q` follow the command or release. The bench keeps a behavioural model that is updated at each rising edge from the same inputs. It compares every output at the next falling edge, so each result is checked in the cycle it is due. Directed checks measure strobe intervals, from one observed pulse to the next, and count pulses over windows in halt, stop and wait. These checks skip the command cycle itself, in which a boundary computed before the mode change may still fire.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STOP = 2'd2,
    ST_WAIT = 2'd3
  } scs_state_e;

  localparam logic [1:0] SPD_SLOW = 2'b00;
  localparam logic [1:0] SPD_MID  = 2'b10;
  localparam logic [1:0] SPD_FAST = 2'b11;
endpackage

// File: rtl/scs_prescaler.sv
module scs_prescaler #(
  parameter int TAP_LO = 3,
  parameter int TAP_HI = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fx_en,
  output logic [TAP_HI-TAP_LO:0]   taps
);
  localparam int NTAP = TAP_HI - TAP_LO + 1;

  logic [TAP_HI-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fx_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // each tap fires when the low bits of the count wrap
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam int BITS = TAP_LO + k;
    always_ff @(posedge clk) begin
      if (rst) begin
        taps[k] <= 1'b0;
      end else begin
        taps[k] <= fx_en && (&cnt_q[BITS-1:0]);
      end
    end
  end
endmodule

// File: rtl/scs_standby.sv
module scs_standby
  import scs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_cmd,
  input  logic       stop_cmd,
  input  logic       int_release,
  input  logic       bt_release,
  output scs_state_e state_q,
  output logic       stop_exit,
  output logic       osc_off
);
  scs_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (stop_cmd)      state_d = ST_STOP;
        else if (halt_cmd) state_d = ST_HALT;
      end
      ST_HALT: if (int_release) state_d = ST_RUN;
      ST_STOP: if (int_release) state_d = ST_WAIT;
      ST_WAIT: if (bt_release)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign stop_exit = (state_q == ST_STOP) && int_release;
  assign osc_off   = (state_q == ST_STOP);
endmodule

// File: rtl/scs_phi_gen.sv
module scs_phi_gen
  import scs_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64,
  parameter int DIV_SUB  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fx_en,
  input  logic       fxt_en,
  input  logic       run,
  input  logic       stop_exit,
  input  logic       pcc_wr,
  input  logic [1:0] pcc_speed,
  input  logic       scc_wr,
  input  logic       scc_sub,
  output logic       phi_q,
  output logic [1:0] act_speed_q,
  output logic       act_sub_q
);
  localparam int MAX_A   = (DIV_FAST > DIV_MID) ? DIV_FAST : DIV_MID;
  localparam int MAX_B   = (DIV_SLOW > DIV_SUB) ? DIV_SLOW : DIV_SUB;
  localparam int DIV_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(DIV_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic [1:0]       pend_speed_q;
  logic             pend_sub_q;
  logic             src_en;
  logic             hit;

  always_comb begin
    if (act_sub_q) begin
      last_cnt = CNT_W'(DIV_SUB - 1);
    end else begin
      case (act_speed_q)
        SPD_FAST: last_cnt = CNT_W'(DIV_FAST - 1);
        SPD_MID:  last_cnt = CNT_W'(DIV_MID - 1);
        default:  last_cnt = CNT_W'(DIV_SLOW - 1);
      endcase
    end
  end

  assign src_en = act_sub_q ? fxt_en : fx_en;
  assign hit    = run && src_en && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      pend_speed_q <= SPD_SLOW;
      pend_sub_q   <= 1'b0;
      act_speed_q  <= SPD_SLOW;
      act_sub_q    <= 1'b0;
      phi_q        <= 1'b0;
    end else begin
      phi_q <= hit;
      if (pcc_wr) pend_speed_q <= pcc_speed;
      if (scc_wr) pend_sub_q   <= scc_sub;
      if (stop_exit) begin
        // leaving stop forces the slowest main rate
        pend_speed_q <= SPD_SLOW;
        act_speed_q  <= SPD_SLOW;
        cnt_q        <= '0;
      end else if (hit) begin
        cnt_q       <= '0;
        act_speed_q <= pend_speed_q;
        act_sub_q   <= pend_sub_q;
      end else if (run && src_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysclk_standby_ctrl.sv
module sysclk_standby_ctrl
  import scs_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64,
  parameter int DIV_SUB  = 4,
  parameter int TAP_LO   = 3,
  parameter int TAP_HI   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fx_tick,
  input  logic                   fxt_tick,
  input  logic                   pcc_wr,
  input  logic [1:0]             pcc_speed,
  input  logic                   scc_wr,
  input  logic                   scc_sub,
  input  logic                   halt_cmd,
  input  logic                   stop_cmd,
  input  logic                   int_release,
  input  logic                   bt_release,
  output logic                   phi_tick,
  output logic                   osc_disable,
  output logic [1:0]             speed_q,
  output logic                   sub_active,
  output logic [TAP_HI-TAP_LO:0] periph_tick
);
  scs_state_e st_q;
  logic       stop_exit;
  logic       osc_off;
  logic       fx_eff;
  logic       run;

  scs_standby u_standby (
    .clk        (clk),
    .rst        (rst),
    .halt_cmd   (halt_cmd),
    .stop_cmd   (stop_cmd),
    .int_release(int_release),
    .bt_release (bt_release),
    .state_q    (st_q),
    .stop_exit  (stop_exit),
    .osc_off    (osc_off)
  );

  assign fx_eff      = fx_tick & ~osc_off;
  assign run         = (st_q == ST_RUN);
  assign osc_disable = osc_off;

  scs_phi_gen #(
    .DIV_FAST(DIV_FAST),
    .DIV_MID (DIV_MID),
    .DIV_SLOW(DIV_SLOW),
    .DIV_SUB (DIV_SUB)
  ) u_phi (
    .clk        (clk),
    .rst        (rst),
    .fx_en      (fx_eff),
    .fxt_en     (fxt_tick),
    .run        (run),
    .stop_exit  (stop_exit),
    .pcc_wr     (pcc_wr),
    .pcc_speed  (pcc_speed),
    .scc_wr     (scc_wr),
    .scc_sub    (scc_sub),
    .phi_q      (phi_tick),
    .act_speed_q(speed_q),
    .act_sub_q  (sub_active)
  );

  scs_prescaler #(
    .TAP_LO(TAP_LO),
    .TAP_HI(TAP_HI)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .fx_en(fx_eff),
    .taps (periph_tick)
  );
endmodule

// File: rtl/sysclk_standby_ctrl_checker.sv
module sysclk_standby_ctrl_checker
  import scs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       halt_cmd,
  input logic       stop_cmd,
  input logic       int_release,
  input logic       phi_tick,
  input logic       osc_disable,
  input logic [1:0] speed_q,
  input logic       sub_active,
  input logic       periph0,
  input scs_state_e st_q
);
  assert_phi_single_R2: assert property (@(posedge clk) disable iff (rst)
    phi_tick |=> !phi_tick);

  assert_apply_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    (!phi_tick && $past(st_q) != ST_STOP) |-> ($stable(speed_q) && $stable(sub_active)));

  assert_frozen_in_standby_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |=> !phi_tick);

  assert_stop_disables_osc_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && stop_cmd) |=> osc_disable);

  assert_stop_exit_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STOP && int_release) |=> (speed_q == 2'b00 && !osc_disable));

  assert_no_stop_from_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && stop_cmd) |=> !osc_disable);

  assert_tap_single_R9: assert property (@(posedge clk) disable iff (rst)
    periph0 |=> !periph0);
endmodule

bind sysclk_standby_ctrl sysclk_standby_ctrl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .halt_cmd   (halt_cmd),
  .stop_cmd   (stop_cmd),
  .int_release(int_release),
  .phi_tick   (phi_tick),
  .osc_disable(osc_disable),
  .speed_q    (speed_q),
  .sub_active (sub_active),
  .periph0    (periph_tick[0]),
  .st_q       (st_q)
);

// File: tb/sysclk_standby_ctrl_bench.sv
module sysclk_standby_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;
  localparam int SUB_GAP = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fx_tick = 1'b0, fxt_tick = 1'b0;
  logic pcc_wr = 1'b0, scc_wr = 1'b0, scc_sub = 1'b0;
  logic [1:0] pcc_speed = 2'b00;
  logic halt_cmd = 1'b0, stop_cmd = 1'b0, int_release = 1'b0, bt_release = 1'b0;
  logic phi_tick, osc_disable, sub_active;
  logic [1:0] speed_q;
  logic [NT-1:0] periph_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_standby_ctrl u_sysclk_standby_ctrl (
    .clk(clk), .rst(rst), .fx_tick(fx_tick), .fxt_tick(fxt_tick),
    .pcc_wr(pcc_wr), .pcc_speed(pcc_speed), .scc_wr(scc_wr), .scc_sub(scc_sub),
    .halt_cmd(halt_cmd), .stop_cmd(stop_cmd), .int_release(int_release),
    .bt_release(bt_release), .phi_tick(phi_tick), .osc_disable(osc_disable),
    .speed_q(speed_q), .sub_active(sub_active), .periph_tick(periph_tick)
  );

  // behavioural reference: 0 run, 1 halt, 2 stop, 3 wait
  int m_mode = 0, m_pspd = 0, m_aspd = 0, m_phase = 0, m_fx = 0;
  bit m_psub = 0, m_asub = 0;
  bit e_phi = 0, e_osc = 0;
  bit [NT-1:0] e_taps = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_pspd = 0; m_aspd = 0; m_phase = 0; m_fx = 0;
      m_psub = 0; m_asub = 0; e_phi = 0; e_osc = 0; e_taps = '0;
    end else begin
      bit fxe, src, hit, leave;
      int ratio, old_pspd;
      bit old_psub;
      fxe = fx_tick && (m_mode != 2);
      src = m_asub ? fxt_tick : fxe;
      if (m_asub) ratio = 4;
      else if (m_aspd == 3) ratio = 4;
      else if (m_aspd == 2) ratio = 8;
      else ratio = 64;
      hit = (m_mode == 0) && src && (m_phase == ratio - 1);
      e_phi = hit;
      for (int k = 0; k < NT; k++)
        e_taps[k] = fxe && ((m_fx % (1 << (k + 3))) == (1 << (k + 3)) - 1);
      if (fxe) m_fx = (m_fx + 1) % 4096;
      leave = (m_mode == 2) && int_release;
      old_pspd = m_pspd; old_psub = m_psub;
      if (pcc_wr) m_pspd = int'(pcc_speed);
      if (scc_wr) m_psub = scc_sub;
      if (leave) begin
        m_pspd = 0; m_aspd = 0; m_phase = 0;
      end else if (hit) begin
        m_phase = 0; m_aspd = old_pspd; m_asub = old_psub;
      end else if (m_mode == 0 && src) begin
        m_phase++;
      end
      case (m_mode)
        0: if (stop_cmd) m_mode = 2; else if (halt_cmd) m_mode = 1;
        1: if (int_release) m_mode = 0;
        2: if (int_release) m_mode = 3;
        default: if (bt_release) m_mode = 0;
      endcase
      e_osc = (m_mode == 2);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst) begin
      chk(phi_tick == e_phi, tag, "model phi_tick", int'(phi_tick), int'(e_phi));
      chk(osc_disable == e_osc, "R6", "model osc_disable", int'(osc_disable), int'(e_osc));
      chk(int'(speed_q) == m_aspd, "R4", "model speed_q", int'(speed_q), m_aspd);
      chk(sub_active == m_asub, "R3", "model sub_active", int'(sub_active), int'(m_asub));
      chk(periph_tick == e_taps, "R9", "model periph_tick", int'(periph_tick), int'(e_taps));
    end
    pcc_wr = 0; scc_wr = 0; halt_cmd = 0; stop_cmd = 0; int_release = 0; bt_release = 0;
    fx_tick = 1'b1;
    fxt_tick = (cyc % SUB_GAP) == 0;
  endtask

  task automatic wait_phi(output int n);
    n = 0;
    do begin tick(); n++; end while (!phi_tick && n < 5000);
  endtask

  task automatic period(output int n);
    int d;
    wait_phi(d);
    wait_phi(n);
  endtask

  task automatic count_phi(input int len, output int c);
    c = 0;
    for (int i = 0; i < len; i++) begin tick(); if (phi_tick) c++; end
  endtask

  task automatic tap_period(input int k, output int n);
    n = 0;
    do tick(); while (!periph_tick[k]);
    do begin tick(); n++; end while (!periph_tick[k] && n < 5000);
  endtask

  task automatic set_speed(input logic [1:0] s);
    pcc_wr = 1; pcc_speed = s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, c, d;
    repeat (3) tick();
    rst = 0;
    tick();
    tag = "R1";
    chk(!phi_tick && !osc_disable && !sub_active && speed_q == 2'b00 && periph_tick == '0,
        "R1", "reset state", int'({phi_tick, osc_disable, sub_active, speed_q}), 0);

    tag = "R2";
    period(n); chk(n == 64, "R2", "slow period", n, 64);

    // R4: write mid-interval, old ratio finishes
    tag = "R4";
    wait_phi(d);
    set_speed(2'b11);
    tick();
    chk(speed_q == 2'b00, "R4", "speed held before boundary", int'(speed_q), 0);
    wait_phi(n); n = n + 1;
    chk(n == 64, "R4", "interval in progress at old ratio", n, 64);
    chk(speed_q == 2'b11, "R4", "speed applied at boundary", int'(speed_q), 3);
    wait_phi(n); chk(n == 4, "R2", "fast period", n, 4);

    tag = "R2";
    set_speed(2'b10); period(n); period(n);
    chk(n == 8, "R2", "mid period", n, 8);
    set_speed(2'b01); period(n); period(n);
    chk(n == 64, "R2", "code 01 slow period", n, 64);

    tag = "R3";
    scc_wr = 1; scc_sub = 1; period(n); period(n);
    chk(n == 4 * SUB_GAP, "R3", "subsystem period", n, 4 * SUB_GAP);
    chk(sub_active == 1'b1, "R3", "sub_active", int'(sub_active), 1);
    scc_wr = 1; scc_sub = 0; set_speed(2'b11); period(n); period(n);
    chk(n == 4 && !sub_active, "R3", "back to main fast", n, 4);

    // R5 halt
    tag = "R5";
    halt_cmd = 1; tick();
    count_phi(300, c); chk(c == 0, "R5", "no phi in halt", c, 0);
    chk(!osc_disable, "R5", "osc on in halt", int'(osc_disable), 0);
    stop_cmd = 1; count_phi(20, c);
    chk(!osc_disable, "R8", "stop ignored in halt", int'(osc_disable), 0);
    int_release = 1; period(n);
    chk(n == 4, "R5", "resume after halt", n, 4);

    // R8 ignored releases in run
    tag = "R8";
    int_release = 1; bt_release = 1; tick(); period(n);
    chk(n == 4, "R8", "releases in run ignored", n, 4);

    // R6 stop with simultaneous halt
    tag = "R6";
    stop_cmd = 1; halt_cmd = 1; tick(); tick();
    chk(osc_disable == 1'b1, "R8", "stop wins over halt", int'(osc_disable), 1);
    c = 0;
    for (int i = 0; i < 200; i++) begin tick(); if (periph_tick != '0) c++; end
    chk(c == 0, "R6", "no taps while osc off", c, 0);
    halt_cmd = 1; tick();
    chk(osc_disable == 1'b1, "R8", "halt ignored in stop", int'(osc_disable), 1);
    tag = "R7";
    int_release = 1; tick(); tick();
    chk(!osc_disable, "R7", "osc on after release", int'(osc_disable), 0);
    chk(speed_q == 2'b00, "R7", "speed cleared", int'(speed_q), 0);
    stop_cmd = 1; count_phi(200, c);
    chk(c == 0, "R7", "phi held until timer release", c, 0);
    chk(!osc_disable, "R8", "stop ignored in wait", int'(osc_disable), 0);
    bt_release = 1; period(n);
    chk(n == 64, "R7", "slow rate after stop", n, 64);

    tag = "R9";
    tap_period(0, n); chk(n == 8, "R9", "fX/8 tap", n, 8);
    tap_period(NT - 1, n); chk(n == 4096, "R9", "fX/4096 tap", n, 4096);

    // reset during stop
    tag = "R1";
    stop_cmd = 1; tick(); tick();
    rst = 1; tick(); tick(); rst = 0; tick();
    chk(!osc_disable && speed_q == 2'b00, "R1", "reset ends stop", int'(osc_disable), 0);
    period(n); chk(n == 64, "R1", "slow after reset", n, 64);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule